// File: doc/BRIEF.md
# Binary Side-Profile Feature Extractor

This block takes a vehicle's side silhouette as a stream of binary columns and reduces it to four numbers that a downstream classifier uses. A column holds one bit for each sensor in a vertical stack. Each bit says whether that beam is blocked. A new column arrives with a one-cycle enable pulse, typically once per sampling frame.

Within each enabled column, the block updates four values in parallel:

- the tallest column seen so far,
- the number of occupied columns,
- the number of wheel contacts found on the lowest beam,
- the column spacing between the first two wheel contacts.

A start pulse at the arrival of a vehicle clears everything. Between enables the results stay frozen, so the classifier can read them at any time after the vehicle has left.

Top module: `profile_feature_extractor`

## Requirements
- R1: Bit 0 of `col_bits` is the lowest sensor and bit NUM_SENSORS-1 the highest. A 1 means blocked and a 0 means clear. The height of a column is the index of its highest 1 plus one, and 0 for an all-zero column.
- R2: Reset, or `vehicle_start` high at a clock edge, sets all four outputs to zero after that edge. A column presented in the same cycle as `vehicle_start` is discarded.
- R3: When neither `col_valid` nor `vehicle_start` is high at an edge, no output changes.
- R4: `max_height` equals the largest column height among the enabled columns since the last clear. It never exceeds NUM_SENSORS.
- R5: `length` counts the enabled columns with at least one 1 bit. All-zero columns are not counted. The count stops at 2^LEN_W-1.
- R6: `axle_count` rises by one on each enabled column whose bit 0 is 1 and whose previous enabled column since the clear had bit 0 at 0. The first enabled column after a clear is treated as following a clear bottom bit. The count stops at 2^AXLE_W-1.
- R7: `axle_distance` is 0 until a second axle is found. It then equals the number of enabled columns from the first axle column to the second, and stops at 2^DIST_W-1. Later axles do not change it.
- R8: All four outputs reflect an enabled column one clock after its enable edge, and all are computed from that same column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vehicle_start | input | 1 | Clears all features for a new vehicle |
| col_valid | input | 1 | Enable pulse: a new column is present |
| col_bits | input | NUM_SENSORS | Occlusion column, bit 0 at the bottom |
| max_height | output | $clog2(NUM_SENSORS+1) | Tallest column height |
| length | output | LEN_W | Occupied column count |
| axle_count | output | AXLE_W | Wheel contacts on the lowest beam |
| axle_distance | output | DIST_W | Columns between first and second axle |

## Verification
Single-bit columns at each sensor position check the height encoding, and an all-zero column checks that empty frames do not lengthen the vehicle. Bottom-bit sequences with repeated 1s, and with gaps of plain columns between wheel contacts, separate edge detection from level detection. These sequences also show whether the spacing counts columns or edges. Long runs push length, axle count and spacing into saturation. Random silhouettes with random bottom bits then stress all four features together against a bench model. A start issued together with a column shows whether the clear takes priority.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

   // Progress of the axle spacing measurement within one vehicle
   typedef enum logic [1:0] {
      SPAN_WAIT  = 2'd0,  // no axle yet
      SPAN_COUNT = 2'd1,  // first axle seen, counting columns
      SPAN_HELD  = 2'd2   // second axle seen, spacing frozen
   } span_phase_e;

endpackage

// File: rtl/pfe_height_unit.sv
module pfe_height_unit #(
   parameter int NUM_SENSORS = 10,
   parameter int HEIGHT_W    = $clog2(NUM_SENSORS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   en,
   input  logic [NUM_SENSORS-1:0] col,
   output logic [HEIGHT_W-1:0]    peak
);

   // Per-position candidate heights; the highest set bit wins
   logic [HEIGHT_W-1:0] cand [NUM_SENSORS];
   logic [HEIGHT_W-1:0] col_height;

   for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_cand
      assign cand[g] = col[g] ? HEIGHT_W'(g + 1) : '0;
   end

   always_comb begin
      col_height = '0;
      for (int i = 0; i < NUM_SENSORS; i++) begin
         if (cand[i] > col_height) col_height = cand[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak <= '0;
      end else if (clear) begin
         peak <= '0;
      end else if (en && (col_height > peak)) begin
         peak <= col_height;
      end
   end

endmodule

// File: rtl/pfe_length_unit.sv
module pfe_length_unit #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             occupied,
   output logic [LEN_W-1:0] count
);

   localparam logic [LEN_W-1:0] LEN_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (en && occupied && (count != LEN_TOP)) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/pfe_axle_unit.sv
module pfe_axle_unit
   import pfe_pkg::*;
#(
   parameter int AXLE_W = 4,
   parameter int DIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              en,
   input  logic              bottom,
   output logic [AXLE_W-1:0] axles,
   output logic [DIST_W-1:0] spacing
);

   localparam logic [AXLE_W-1:0] AXLE_TOP = '1;
   localparam logic [DIST_W-1:0] DIST_TOP = '1;

   logic              prev_bottom;
   span_phase_e       phase;
   logic [DIST_W-1:0] span_cnt;
   logic [DIST_W-1:0] span_next;
   logic              contact;

   assign contact   = bottom && !prev_bottom;
   assign span_next = (span_cnt == DIST_TOP) ? DIST_TOP : span_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_bottom <= 1'b0;
         axles       <= '0;
         phase       <= SPAN_WAIT;
         span_cnt    <= '0;
         spacing     <= '0;
      end else if (clear) begin
         prev_bottom <= 1'b0;
         axles       <= '0;
         phase       <= SPAN_WAIT;
         span_cnt    <= '0;
         spacing     <= '0;
      end else if (en) begin
         prev_bottom <= bottom;
         if (contact && (axles != AXLE_TOP)) axles <= axles + 1'b1;
         unique case (phase)
            SPAN_WAIT: begin
               if (contact) begin
                  phase    <= SPAN_COUNT;
                  span_cnt <= '0;
               end
            end
            SPAN_COUNT: begin
               if (contact) begin
                  spacing <= span_next;
                  phase   <= SPAN_HELD;
               end else begin
                  span_cnt <= span_next;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/profile_feature_extractor.sv
module profile_feature_extractor #(
   parameter int  NUM_SENSORS = 10,
   parameter int  LEN_W       = 12,
   parameter int  AXLE_W      = 4,
   parameter int  DIST_W      = 8,
   localparam int HEIGHT_W    = $clog2(NUM_SENSORS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vehicle_start,
   input  logic                   col_valid,
   input  logic [NUM_SENSORS-1:0] col_bits,
   output logic [HEIGHT_W-1:0]    max_height,
   output logic [LEN_W-1:0]       length,
   output logic [AXLE_W-1:0]      axle_count,
   output logic [DIST_W-1:0]      axle_distance
);

   // Elaboration-time parameter checks
   if (NUM_SENSORS < 2) begin : g_bad_sensors
      $error("NUM_SENSORS must be at least 2");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("LEN_W must be at least 2");
   end
   if (AXLE_W < 1) begin : g_bad_axle
      $error("AXLE_W must be at least 1");
   end
   if (DIST_W < 2) begin : g_bad_dist
      $error("DIST_W must be at least 2");
   end

   logic col_occupied;
   assign col_occupied = |col_bits;

   pfe_height_unit #(
      .NUM_SENSORS (NUM_SENSORS),
      .HEIGHT_W    (HEIGHT_W)
   ) u_height (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (vehicle_start),
      .en    (col_valid),
      .col   (col_bits),
      .peak  (max_height)
   );

   pfe_length_unit #(
      .LEN_W (LEN_W)
   ) u_length (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (vehicle_start),
      .en       (col_valid),
      .occupied (col_occupied),
      .count    (length)
   );

   pfe_axle_unit #(
      .AXLE_W (AXLE_W),
      .DIST_W (DIST_W)
   ) u_axle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (vehicle_start),
      .en      (col_valid),
      .bottom  (col_bits[0]),
      .axles   (axle_count),
      .spacing (axle_distance)
   );

endmodule

// File: rtl/pfe_checks.sv
module pfe_checks #(
   parameter int  NUM_SENSORS = 10,
   parameter int  LEN_W       = 12,
   parameter int  AXLE_W      = 4,
   parameter int  DIST_W      = 8,
   localparam int HEIGHT_W    = $clog2(NUM_SENSORS + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   vehicle_start,
   input logic                   col_valid,
   input logic [NUM_SENSORS-1:0] col_bits,
   input logic [HEIGHT_W-1:0]    max_height,
   input logic [LEN_W-1:0]       length,
   input logic [AXLE_W-1:0]      axle_count,
   input logic [DIST_W-1:0]      axle_distance
);

   localparam logic [LEN_W-1:0] LEN_TOP = '1;

   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      vehicle_start |=> (max_height == '0) && (length == '0) &&
                        (axle_count == '0) && (axle_distance == '0)); // R2

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!vehicle_start && !col_valid) |=> $stable(max_height) && $stable(length) &&
                                         $stable(axle_count) && $stable(axle_distance)); // R3

   AST_HEIGHT_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !vehicle_start |=> (max_height >= $past(max_height))); // R4

   AST_HEIGHT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      max_height <= HEIGHT_W'(NUM_SENSORS)); // R4

   AST_LENGTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!vehicle_start && col_valid && (col_bits != '0) && (length != LEN_TOP))
         |=> (length == $past(length) + 1'b1)); // R5

   AST_EMPTY_COLUMN_NO_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (!vehicle_start && col_valid && (col_bits == '0)) |=> $stable(length)); // R5

   AST_AXLE_NEEDS_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (!vehicle_start && !(col_valid && col_bits[0])) |=> $stable(axle_count)); // R6

   AST_AXLE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !vehicle_start |=> ((axle_count == $past(axle_count)) ||
                          (axle_count == $past(axle_count) + 1'b1))); // R6

   AST_DISTANCE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!vehicle_start && (axle_distance != '0)) |=> $stable(axle_distance)); // R7

endmodule

bind profile_feature_extractor pfe_checks #(
   .NUM_SENSORS (NUM_SENSORS),
   .LEN_W       (LEN_W),
   .AXLE_W      (AXLE_W),
   .DIST_W      (DIST_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .vehicle_start (vehicle_start),
   .col_valid     (col_valid),
   .col_bits      (col_bits),
   .max_height    (max_height),
   .length        (length),
   .axle_count    (axle_count),
   .axle_distance (axle_distance)
);

// File: tb/profile_feature_extractor_tb.sv
module profile_feature_extractor_tb;

   localparam int NS   = 10;
   localparam int LMAX = 4095;
   localparam int AMAX = 15;
   localparam int DMAX = 255;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vehicle_start = 1'b0;
   logic          col_valid = 1'b0;
   logic [NS-1:0] col_bits = '0;
   logic [3:0]    max_height;
   logic [11:0]   length;
   logic [3:0]    axle_count;
   logic [7:0]    axle_distance;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // Bench model of the expected features
   int m_h, m_len, m_ax, m_prev0, m_idx, m_a1, m_a2;

   always #4 clk = ~clk;

   profile_feature_extractor u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .vehicle_start (vehicle_start),
      .col_valid     (col_valid),
      .col_bits      (col_bits),
      .max_height    (max_height),
      .length        (length),
      .axle_count    (axle_count),
      .axle_distance (axle_distance)
   );

   function automatic int col_h(logic [NS-1:0] c);
      int r = 0;
      for (int i = 0; i < NS; i++) if (c[i]) r = i + 1;
      return r;
   endfunction

   function automatic int exp_dist();
      if (m_a2 < 0) return 0;
      return (m_a2 - m_a1 > DMAX) ? DMAX : m_a2 - m_a1;
   endfunction

   task automatic model_clear();
      m_h = 0; m_len = 0; m_ax = 0; m_prev0 = 0; m_idx = 0; m_a1 = -1; m_a2 = -1;
   endtask

   task automatic model_col(logic [NS-1:0] c);
      if (col_h(c) > m_h) m_h = col_h(c);
      if (c != '0 && m_len < LMAX) m_len++;
      if (c[0] && m_prev0 == 0) begin
         if (m_ax < AMAX) m_ax++;
         if (m_a1 < 0) m_a1 = m_idx;
         else if (m_a2 < 0) m_a2 = m_idx;
      end
      m_prev0 = c[0];
      m_idx++;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_all(string ctx);
      chk({ctx, " R4 max_height"},    int'(max_height),    m_h);
      chk({ctx, " R5 length"},        int'(length),        m_len);
      chk({ctx, " R6 axle_count"},    int'(axle_count),    m_ax);
      chk({ctx, " R7 axle_distance"}, int'(axle_distance), exp_dist());
   endtask

   task automatic do_col(logic [NS-1:0] c);
      @(negedge clk);
      col_valid = 1'b1; col_bits = c;
      @(negedge clk);
      col_valid = 1'b0; col_bits = '0;
      model_col(c);
   endtask

   task automatic do_start();
      @(negedge clk);
      vehicle_start = 1'b1;
      @(negedge clk);
      vehicle_start = 1'b0;
      model_clear();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      repeat (3) @(negedge clk);
      check_all("reset R2");
      rst_n = 1'b1;

      // R1: height encoding per sensor position
      for (int i = 0; i < NS; i++) begin
         do_start();
         do_col(NS'(1) << i);
         chk("R1 single bit height", int'(max_height), i + 1);
      end
      do_start();
      do_col('0);
      chk("R1 empty column height", int'(max_height), 0);
      chk("R5 empty column length", int'(length), 0);

      // R8: all features from one column, one cycle later
      do_start();
      do_col(10'b0000011111);
      chk("R8 height", int'(max_height), 5);
      chk("R8 length", int'(length), 1);
      chk("R8 axles",  int'(axle_count), 1);
      chk("R8 dist",   int'(axle_distance), 0);

      // R3: hold while idle
      do_col(10'b0011111110);
      repeat (6) @(negedge clk);
      check_all("idle hold R3");

      // R2: start with a same-cycle column
      @(negedge clk);
      vehicle_start = 1'b1; col_valid = 1'b1; col_bits = 10'h3FF;
      @(negedge clk);
      vehicle_start = 1'b0; col_valid = 1'b0; col_bits = '0;
      model_clear();
      check_all("start beats column R2");

      // R6/R7: edge detection on the bottom beam
      do_start();
      do_col(10'h003); do_col(10'h003); do_col(10'h006);
      do_col(10'h003); do_col(10'h002); do_col(10'h000); do_col(10'h001);
      check_all("bottom pattern R6 R7");
      chk("R6 directed axle count", int'(axle_count), 3);
      chk("R7 directed distance", int'(axle_distance), 3);

      // R5 saturation
      do_start();
      for (int i = 0; i < LMAX + 5; i++) do_col(10'h001);
      chk("R5 length saturates", int'(length), LMAX);

      // R6 saturation
      do_start();
      for (int i = 0; i < 20; i++) begin do_col(10'h001); do_col(10'h002); end
      chk("R6 axles saturate", int'(axle_count), AMAX);

      // R7 saturation and freeze
      do_start();
      do_col(10'h001);
      for (int i = 0; i < 300; i++) do_col(10'h002);
      do_col(10'h001);
      chk("R7 distance saturates", int'(axle_distance), DMAX);
      do_col(10'h002); do_col(10'h001);
      chk("R7 distance frozen", int'(axle_distance), DMAX);

      // Random silhouettes
      for (int v = 0; v < 40; v++) begin
         int ncol;
         do_start();
         ncol = 3 + int'($urandom_range(60));
         for (int c = 0; c < ncol; c++) begin
            logic [NS-1:0] bits;
            bits = NS'($urandom);
            if ($urandom_range(3) == 0) bits = '0;
            do_col(bits);
            check_all("random");
            if ($urandom_range(4) == 0) begin
               repeat (2) @(negedge clk);
               check_all("random idle R3");
            end
         end
      end

      summary();
   end

endmodule